// File: doc/BRIEF.md
# Phase-Accumulator LED Dimmer

This block turns three latched 8-bit colour intensities into three on/off drive lines whose duty cycle follows each intensity. Each channel keeps a private 8-bit phase accumulator. On every tick it adds its intensity to that accumulator. The channel's drive line is on for that tick exactly when the addition carries out of the top bit. Because the carries fall wherever the running sum wraps, the on-ticks are spread evenly across the 256-tick period rather than bunched at its start, as a ramp comparator would place them.

A host writes new values into three staging inputs and pulses a latch strobe. The strobe copies all three values into the working registers at once, and those values then hold until the next strobe. A latch does not disturb the accumulators, so the phase carries on across a colour change. The tick input is a one-cycle enable, so a single fast clock can drive any tick rate.

Top module: `led_dither_pwm`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all three drive lines are 0. Reset clears all three accumulators and all three working intensities.
- R2: A tick is a clock edge at which `tick_en` is 1. At that edge each channel computes acc + level as a 9-bit sum. The accumulator takes the low 8 bits, and the drive line takes bit 8 (1 = on). The drive value is visible just after that edge.
- R3: A working intensity of 0 never turns its drive line on.
- R4: Starting from a cleared accumulator, a working intensity of 1 turns the drive line on only at the 256th tick of each 256-tick period.
- R5: A working intensity of 128, starting from a cleared accumulator, gives off, on, off, on, and so on: a 50% duty cycle.
- R6: A working intensity of 255, starting from a cleared accumulator, is off on the first tick and then on for the other 255 ticks of each period. The line is never on for all 256 ticks.
- R7: For every intensity L from 0 to 255, the 256 ticks that start from a cleared accumulator contain exactly L on-ticks. The k-th tick is on exactly when floor(k*L/256) > floor((k-1)*L/256).
- R8: The staging inputs have no effect unless `latch_stb` is 1 at a clock edge.
- R9: When `latch_stb` is 1 at an edge, all three staged values are copied into the working intensities. The accumulators keep their contents, so the next tick adds the new intensity to the old phase.
- R10: At an edge where `tick_en` is 0, the accumulators and the drive lines hold their values.
- R11: The red, green and blue channels are independent. Each channel's output depends only on its own intensity and tick history.
- R12: When a latch and a tick happen at the same edge, that tick uses the previous working intensity. The new intensity applies from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle tick enable |
| latch_stb | input | 1 | Copies the staged intensities into the working registers |
| stage_red | input | 8 | Staged red intensity |
| stage_grn | input | 8 | Staged green intensity |
| stage_blu | input | 8 | Staged blue intensity |
| drive_red | output | 1 | Red on/off drive |
| drive_grn | output | 1 | Green on/off drive |
| drive_blu | output | 1 | Blue on/off drive |

## Verification
A drive line reflects a tick one register stage late. The carry from the tick edge is visible just after that same edge, and it stays until the next tick edge. A latched intensity first affects the tick at the edge after the strobe. The bench therefore drives inputs on the falling edge and samples the outputs 1 ns after the rising edge that consumed them. Every expected value is tied to the tick that produced it. An exhaustive sweep covers all 256 intensities over a full period on every channel and compares each tick against the floor formula. Directed runs then cover latches in mid-period, idle cycles between ticks, and a latch in the same cycle as a tick.

// File: rtl/dim_pkg.sv
package dim_pkg;
    localparam int LVL_W = 8;
    localparam int CH_N  = 3;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        level_t acc;
        logic   drive;
    } phase_t;
endpackage

// File: rtl/dim_level_bank.sv
module dim_level_bank
    import dim_pkg::*;
#(
    parameter int CH = CH_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               latch_stb,
    input  level_t [CH-1:0]    stage_i,
    output level_t [CH-1:0]    lvl_o
);
    typedef struct packed {
        level_t [CH-1:0] lvl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (latch_stb) begin
            bank_d.lvl = stage_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign lvl_o = bank_q.lvl;

    // R8: staged values leave the working registers alone without a strobe
    p_stage_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_stb |=> $stable(lvl_o));

    // R9: a strobe copies every staged value
    p_latch_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> (lvl_o == $past(stage_i)));
endmodule

// File: rtl/dim_phase_channel.sv
module dim_phase_channel
    import dim_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_en,
    input  level_t lvl_i,
    output logic   drive_o
);
    localparam int SUM_W = LVL_W + 1;

    phase_t ph_d, ph_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = {1'b0, ph_q.acc} + {1'b0, lvl_i};
        ph_d = ph_q;
        if (tick_en) begin
            ph_d.acc   = sum[LVL_W-1:0];
            ph_d.drive = sum[LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign drive_o = ph_q.drive;

    // R3: zero intensity never lights
    p_zero_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && lvl_i == '0) |=> !drive_o);

    // R10: no tick, nothing moves
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(ph_q.acc) && $stable(drive_o)));

    // R6: full intensity lights from any nonzero phase
    p_full_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && lvl_i == '1 && ph_q.acc != '0) |=> drive_o);

    // R4: intensity one lights only from the top phase
    p_one_rare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && lvl_i == level_t'(1) && ph_q.acc != '1) |=> !drive_o);

    // R5: half intensity from the half phase lights
    p_half_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && lvl_i == level_t'(1 << (LVL_W-1))
                 && ph_q.acc == level_t'(1 << (LVL_W-1))) |=> drive_o);
endmodule

// File: rtl/led_dither_pwm.sv
module led_dither_pwm
    import dim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       latch_stb,
    input  logic [7:0] stage_red,
    input  logic [7:0] stage_grn,
    input  logic [7:0] stage_blu,
    output logic       drive_red,
    output logic       drive_grn,
    output logic       drive_blu
);
    level_t [CH_N-1:0] stage_vec;
    level_t [CH_N-1:0] lvl_vec;
    logic   [CH_N-1:0] drive_vec;

    assign stage_vec[0] = stage_red;
    assign stage_vec[1] = stage_grn;
    assign stage_vec[2] = stage_blu;

    dim_level_bank #(.CH(CH_N)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_stb (latch_stb),
        .stage_i   (stage_vec),
        .lvl_o     (lvl_vec)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        dim_phase_channel chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .lvl_i   (lvl_vec[c]),
            .drive_o (drive_vec[c])
        );
    end

    assign drive_red = drive_vec[0];
    assign drive_grn = drive_vec[1];
    assign drive_blu = drive_vec[2];

    // R1: drives stay dark through reset
    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (drive_vec == '0));
endmodule

// File: tb/led_dither_pwm_tb.sv
`timescale 1ns/1ps
module led_dither_pwm_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic latch_stb = 1'b0;
    logic [7:0] stage_red = '0, stage_grn = '0, stage_blu = '0;
    logic drive_red, drive_grn, drive_blu;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int lvl_m[3];
    int ph_m[3];
    int exp_m[3];

    always #2 clk = ~clk;

    led_dither_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .latch_stb(latch_stb),
        .stage_red(stage_red), .stage_grn(stage_grn), .stage_blu(stage_blu),
        .drive_red(drive_red), .drive_grn(drive_grn), .drive_blu(drive_blu)
    );

    function automatic logic drv(int c);
        case (c)
            0: return drive_red;
            1: return drive_grn;
            default: return drive_blu;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; latch_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            lvl_m[c] = 0; ph_m[c] = 0; exp_m[c] = 0;
        end
    endtask

    // one cycle; model advances; inputs set on falling edge, sampled 1 ns after rise
    task automatic cycle(bit tk, bit lt, int r, int g, int b);
        @(negedge clk);
        tick_en = tk; latch_stb = lt;
        if (lt) begin
            stage_red = 8'(r); stage_grn = 8'(g); stage_blu = 8'(b);
        end
        @(posedge clk);
        #1;
        if (tk) begin
            for (int c = 0; c < 3; c++) begin
                ph_m[c] += lvl_m[c];
                exp_m[c] = (ph_m[c] >= 256) ? 1 : 0;
                ph_m[c] = ph_m[c] % 256;
            end
        end
        if (lt) begin
            lvl_m[0] = r; lvl_m[1] = g; lvl_m[2] = b;
        end
        @(negedge clk);
        tick_en = 1'b0; latch_stb = 1'b0;
    endtask

    task automatic check_model(string req);
        for (int c = 0; c < 3; c++)
            check(drv(c) == exp_m[c][0], req, int'(drv(c)), exp_m[c]);
    endtask

    initial begin
        #(4ns * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lvls[3];
        int cnt[3];
        int mism[3];
        int first_on[3];
        int alt_bad;
        logic held[3];

        // R1: outputs dark during and after reset
        #1;
        check(drive_red == 0 && drive_grn == 0 && drive_blu == 0, "R1 during reset",
              int'({drive_red, drive_grn, drive_blu}), 0);
        do_reset();
        @(posedge clk); #1;
        check({drive_red, drive_grn, drive_blu} == 3'b000, "R1 after release",
              int'({drive_red, drive_grn, drive_blu}), 0);

        // R8: staged values without strobe do nothing (levels stay 0 -> dark)
        @(negedge clk);
        stage_red = 8'd200; stage_grn = 8'd255; stage_blu = 8'd128;
        for (int k = 0; k < 20; k++) begin
            cycle(1'b1, 1'b0, 0, 0, 0);
            check_model("R8 unlatched stage ignored");
        end

        // R7/R2/R11 exhaustive sweep, with R3..R6 corner tags
        for (int L = 0; L < 256; L++) begin
            do_reset();
            lvls[0] = L; lvls[1] = 255 - L; lvls[2] = L ^ 8'h5A;
            cycle(1'b0, 1'b1, lvls[0], lvls[1], lvls[2]);
            for (int c = 0; c < 3; c++) begin
                cnt[c] = 0; mism[c] = 0; first_on[c] = -1;
            end
            alt_bad = 0;
            for (int k = 1; k <= 256; k++) begin
                @(negedge clk);
                tick_en = 1'b1;
                @(posedge clk);
                #1;
                for (int c = 0; c < 3; c++) begin
                    int e;
                    e = ((k * lvls[c]) / 256 > ((k - 1) * lvls[c]) / 256) ? 1 : 0;
                    if (int'(drv(c)) != e) mism[c]++;
                    if (drv(c)) begin
                        cnt[c]++;
                        if (first_on[c] < 0) first_on[c] = k;
                    end
                end
                if (L == 128 && int'(drive_red) != ((k % 2 == 0) ? 1 : 0)) alt_bad++;
            end
            @(negedge clk);
            tick_en = 1'b0;
            for (int c = 0; c < 3; c++) begin
                check(mism[c] == 0, "R2 per-tick carry pattern", mism[c], 0);
                check(cnt[c] == lvls[c], "R7 on-ticks per period", cnt[c], lvls[c]);
            end
            if (L == 0) check(cnt[0] == 0, "R3 zero never on", cnt[0], 0);
            if (L == 1) check(cnt[0] == 1 && first_on[0] == 256, "R4 one lights at tick 256",
                              first_on[0], 256);
            if (L == 128) check(alt_bad == 0, "R5 half alternates", alt_bad, 0);
            if (L == 0) check(cnt[1] == 255 && first_on[1] == 2, "R6 full off once",
                              first_on[1], 2);
            if (L == 37) check(cnt[2] == (37 ^ 8'h5A) && cnt[0] == 37,
                               "R11 channels independent", cnt[2], 37 ^ 8'h5A);
        end

        // R9: latch mid-period keeps phase
        do_reset();
        cycle(1'b0, 1'b1, 128, 64, 200);
        cycle(1'b1, 1'b0, 0, 0, 0);
        check_model("R9 before relatch");
        cycle(1'b0, 1'b1, 64, 200, 1);
        for (int k = 0; k < 12; k++) begin
            cycle(1'b1, 1'b0, 0, 0, 0);
            check_model("R9 phase kept across latch");
        end

        // R10: idle cycles hold outputs
        do_reset();
        cycle(1'b0, 1'b1, 128, 255, 3);
        cycle(1'b1, 1'b0, 0, 0, 0);
        cycle(1'b1, 1'b0, 0, 0, 0);
        for (int c = 0; c < 3; c++) held[c] = drv(c);
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0, 1'b0, 0, 0, 0);
            for (int c = 0; c < 3; c++)
                check(drv(c) == held[c], "R10 idle hold", int'(drv(c)), int'(held[c]));
        end
        for (int k = 0; k < 8; k++) begin
            cycle(1'b1, 1'b0, 0, 0, 0);
            check_model("R10 resume after idle");
        end

        // R12: latch and tick together uses old level for that tick
        do_reset();
        cycle(1'b0, 1'b1, 0, 0, 0);
        cycle(1'b1, 1'b1, 255, 255, 255);
        check({drive_red, drive_grn, drive_blu} == 3'b000, "R12 same-edge old level",
              int'({drive_red, drive_grn, drive_blu}), 0);
        cycle(1'b1, 1'b0, 0, 0, 0);
        check_model("R12 new level next tick");
        cycle(1'b1, 1'b0, 0, 0, 0);
        check({drive_red, drive_grn, drive_blu} == 3'b111, "R12 full level on",
              int'({drive_red, drive_grn, drive_blu}), 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule